// File: doc/BRIEF.md
# Serial Wire Debug Host Engine

This block is the host end of a two-wire serial debug link. It carries out one register access at a time: a caller hands over the target port (debug port or access port), the direction, a two-bit register index and, for a write, a 32-bit word. The engine generates the debug clock itself and serialises the 8-bit request header. It releases the data line for a programmable turnaround, collects the 3-bit acknowledge, and then moves the data word with its parity bit.

Every access ends with a one-cycle completion pulse. The pulse carries the acknowledge code, the read word and a read-parity flag. Any acknowledge other than OK ends the access without a data phase and without a retry. The caller then decides how to handle WAIT, FAULT or a malformed response.

Each bit on the wire takes two system clocks. The debug clock is low for the first clock and high for the second. The engine changes what it drives only when the debug clock falls, and it samples the line when the debug clock rises. The data line appears as separate output, output-enable and input pins, so that a pad or a testbench can resolve it.

Top module: `swd_host_engine`

## Requirements
- R1: `req_ready` is high only while the engine is idle, and a request is taken only when `req_valid` and `req_ready` are both high. Request inputs that change while busy have no effect on the access in progress. While idle, `swclk` is low and, unless R8 applies, the host drives `swdio_out` low with `swdio_oe` high.
- R2: Each bit occupies two clocks, with `swclk` low in the first and high in the second. `swdio_oe` and `swdio_out` change only at the clock edge that starts a bit. `swdio_in` is sampled at the edge where `swclk` rises.
- R3: The header goes out least significant bit first, in the bit right after the request is accepted. Its bits are: bit0 start = 1, bit1 = `req_ap`, bit2 = `req_read`, bit3 = `req_addr[0]`, bit4 = `req_addr[1]`, bit5 parity, bit6 stop = 0. Bit7 (park) is not driven (`swdio_oe` low).
- R4: Header bit5 is the XOR of `req_ap`, `req_read`, `req_addr[1]` and `req_addr[0]`.
- R5: After park, the line is released for `trn_len`+1 bits, and then three acknowledge bits are sampled with the line still released. The same `trn_len`+1 released bits also appear between an OK acknowledge and write data, after read data, and after a WAIT or FAULT acknowledge.
- R6: The acknowledge is assembled least significant bit first, so the first bit received becomes `ack[0]`. The value 3'b001 (OK) continues the access into its data phase.
- R7: A WAIT (3'b010) or FAULT (3'b100) acknowledge skips the data phase. The access ends after one turnaround, and the host then drives the line low again.
- R8: Any other acknowledge ends the access right after the third acknowledge bit, with no turnaround. `swdio_oe` then stays low until the next request is accepted.
- R9: After an OK acknowledge on a write, 32 data bits are driven least significant bit first, then one bit equal to the XOR of the word. The access ends after that parity bit.
- R10: After an OK acknowledge on a read, 32 data bits are sampled least significant bit first, then a parity bit. `rdata` returns the word, and `par_err` is 1 exactly when the XOR of the 32 bits and the parity bit is 1.
- R11: `done` is high for exactly one clock, in the first idle clock after an access. `ack`, `rdata` and `par_err` are valid in that clock and hold until the next access changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trn_len | input | TRN_W | Turnaround length minus one, in bits |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_ap | input | 1 | 1 = access port, 0 = debug port |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | 2 | Register address bits A[3:2] |
| req_wdata | input | DW | Write word |
| swclk | output | 1 | Debug clock |
| swdio_out | output | 1 | Host data value |
| swdio_oe | output | 1 | Host drives data line when 1 |
| swdio_in | input | 1 | Resolved data line |
| done | output | 1 | One-clock completion pulse |
| ack | output | 3 | Acknowledge received |
| rdata | output | DW | Read word |
| par_err | output | 1 | Read parity mismatch |

## Verification
The bench runs a cycle-by-cycle reference of the wire for accesses that differ in port, direction, address, data and turnaround length. Writes with words of opposite parity show whether the data parity bit is computed and placed correctly. Several header combinations tell parity bit5 apart from the address and direction bits. Reads with good and corrupted parity separate returning the word from flagging the error. Acknowledges of OK, WAIT, FAULT, all-ones and all-zeros each select a different ending, and the timing of the ending and the idle drive state show which one was taken. A request offered in the middle of an access shows that a busy engine ignores it.

// File: rtl/swd_host_engine.sv
module swd_host_engine #(
  parameter int DW    = 32,
  parameter int TRN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TRN_W-1:0] trn_len,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_ap,
  input  logic             req_read,
  input  logic [1:0]       req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             swclk,
  output logic             swdio_out,
  output logic             swdio_oe,
  input  logic             swdio_in,
  output logic             done,
  output logic [2:0]       ack,
  output logic [DW-1:0]    rdata,
  output logic             par_err
);
  localparam int CW = $clog2(DW + 1) + 1;
  localparam logic [2:0] ACK_OK = 3'b001, ACK_WAIT = 3'b010, ACK_FAULT = 3'b100;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_TRN1, S_ACK, S_TRN2, S_WDAT, S_RDAT} st_t;

  st_t              st;
  logic             ph, rd_q;
  logic [CW-1:0]    cnt;
  logic [TRN_W-1:0] trn_q;
  logic [7:0]       hdr;
  logic [DW:0]      wsh, rsh;
  logic [2:0]       ack_sh;

  assign req_ready = (st == S_IDLE);
  assign swclk     = ph;

  wire trn_last = (cnt == CW'(trn_q));
  wire dat_last = (cnt == CW'(DW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= 1'b0; cnt <= '0; rd_q <= 1'b0; trn_q <= '0;
      hdr <= '0; wsh <= '0; rsh <= '0; ack_sh <= '0;
      swdio_oe <= 1'b1; swdio_out <= 1'b0;
      done <= 1'b0; ack <= '0; rdata <= '0; par_err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        if (req_valid) begin
          st        <= S_REQ;
          cnt       <= '0;
          rd_q      <= req_read;
          trn_q     <= trn_len;
          hdr       <= {2'b10, ^{req_ap, req_read, req_addr}, req_addr[1], req_addr[0],
                        req_read, req_ap, 1'b1};
          wsh       <= {^req_wdata, req_wdata};
          par_err   <= 1'b0;
          swdio_oe  <= 1'b1;
          swdio_out <= 1'b1;
        end
      end else if (!ph) begin
        ph <= 1'b1;
        if (st == S_ACK)  ack_sh[cnt[1:0]] <= swdio_in;
        if (st == S_RDAT) rsh[cnt]         <= swdio_in;
      end else begin
        ph  <= 1'b0;
        cnt <= cnt + 1'b1;
        unique case (st)
          S_REQ: begin
            if (cnt == CW'(6)) swdio_oe <= 1'b0;
            else if (cnt == CW'(7)) begin st <= S_TRN1; cnt <= '0; end
            else swdio_out <= hdr[cnt[2:0] + 3'd1];
          end
          S_TRN1: if (trn_last) begin st <= S_ACK; cnt <= '0; end
          S_ACK: if (cnt == CW'(2)) begin
            ack <= ack_sh;
            cnt <= '0;
            if (ack_sh == ACK_OK && rd_q) st <= S_RDAT;
            else if (ack_sh == ACK_OK || ack_sh == ACK_WAIT || ack_sh == ACK_FAULT) st <= S_TRN2;
            else begin st <= S_IDLE; done <= 1'b1; swdio_out <= 1'b0; end
          end
          S_TRN2: if (trn_last) begin
            if (ack == ACK_OK && !rd_q) begin
              st <= S_WDAT; cnt <= '0; swdio_oe <= 1'b1; swdio_out <= wsh[0];
            end else begin
              st <= S_IDLE; done <= 1'b1; swdio_oe <= 1'b1; swdio_out <= 1'b0;
            end
          end
          S_WDAT: begin
            if (dat_last) begin st <= S_IDLE; done <= 1'b1; swdio_out <= 1'b0; end
            else swdio_out <= wsh[cnt + 1'b1];
          end
          S_RDAT: if (dat_last) begin
            st <= S_TRN2; cnt <= '0;
            rdata <= rsh[DW-1:0];
            par_err <= ^rsh;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/swd_host_engine_chk.sv
module swd_host_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       swclk,
  input logic       swdio_oe,
  input logic       swdio_out,
  input logic       done,
  input logic [2:0] ack
);
  AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !swclk); // R1
  AST_DRIVE_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    swclk |-> ($stable(swdio_oe) && $stable(swdio_out))); // R2
  AST_CLK_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !swclk) |=> swclk); // R2
  AST_START_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (swdio_oe && swdio_out && !swclk)); // R3
  AST_BAD_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ack != 3'b001 && ack != 3'b010 && ack != 3'b100) |-> !swdio_oe); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
endmodule

bind swd_host_engine swd_host_engine_chk u_chk (.*);

// File: tb/tb_swd_host_engine.sv
`timescale 1ns/1ps
module tb_swd_host_engine;
  localparam int DW = 32;
  localparam int TRN_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [TRN_W-1:0] trn_len = '0;
  logic req_valid = 1'b0, req_ap = 1'b0, req_read = 1'b0;
  logic [1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic swdio_in = 1'b1;
  logic req_ready, swclk, swdio_out, swdio_oe, done, par_err;
  logic [2:0] ack;
  logic [DW-1:0] rdata;

  int checks = 0, fails = 0, cycles = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  swd_host_engine #(.DW(DW), .TRN_W(TRN_W)) dut (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !finished) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, cycles=%0d expected<100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic slot(input bit xoe, input bit xout, input bit tgt, input string tag);
    swdio_in = xoe ? xout : tgt;
    for (int h = 0; h < 2; h++) begin
      chk(swclk === h[0] && swdio_oe === xoe && (!xoe || swdio_out === xout) &&
          done === 1'b0 && req_ready === 1'b0,
          $sformatf("%s: clk=%b oe=%b out=%b done=%b rdy=%b expected clk=%b oe=%b out=%b done=0 rdy=0",
                    tag, swclk, swdio_oe, swdio_out, done, req_ready, h[0], xoe, xout));
      @(negedge clk);
    end
  endtask

  task automatic access(input bit ap, input bit rd, input logic [1:0] a,
                        input logic [DW-1:0] data, input logic [TRN_W-1:0] trn,
                        input logic [2:0] tack, input bit flip_par, input bit glitch);
    logic [7:0] h;
    bit okk, wf;
    h = {2'b10, ap ^ rd ^ a[1] ^ a[0], a[1], a[0], rd, ap, 1'b1};
    okk = (tack == 3'b001);
    wf  = (tack == 3'b010 || tack == 3'b100);
    req_ap = ap; req_read = rd; req_addr = a; req_wdata = data; trn_len = trn;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    req_ap = ~ap; req_read = ~rd; req_addr = ~a; req_wdata = ~data;
    for (int i = 0; i < 7; i++) slot(1'b1, h[i], 1'b1, (i == 5) ? "R4 header parity" : "R3 header");
    slot(1'b0, 1'b0, 1'b1, "R3 park");
    for (int i = 0; i <= int'(trn); i++) slot(1'b0, 1'b0, 1'b1, "R5 turnaround");
    if (glitch) req_valid = 1'b1;
    for (int i = 0; i < 3; i++) slot(1'b0, 1'b0, tack[i], "R6 ack");
    req_valid = 1'b0;
    if (okk && rd) begin
      for (int i = 0; i < DW; i++) slot(1'b0, 1'b0, data[i], "R10 read data");
      slot(1'b0, 1'b0, (^data) ^ flip_par, "R10 read parity");
      for (int i = 0; i <= int'(trn); i++) slot(1'b0, 1'b0, 1'b1, "R5 turnaround after read");
    end else if (okk) begin
      for (int i = 0; i <= int'(trn); i++) slot(1'b0, 1'b0, 1'b1, "R5 turnaround before write");
      for (int i = 0; i < DW; i++) slot(1'b1, data[i], 1'b1, "R9 write data");
      slot(1'b1, ^data, 1'b1, "R9 write parity");
    end else if (wf) begin
      for (int i = 0; i <= int'(trn); i++) slot(1'b0, 1'b0, 1'b1, "R7 turnaround after wait/fault");
    end
    swdio_in = 1'b1;
    chk(done === 1'b1 && ack === tack && swclk === 1'b0 && req_ready === 1'b1,
        $sformatf("R11 completion: done=%b ack=%b clk=%b rdy=%b expected done=1 ack=%b clk=0 rdy=1",
                  done, ack, swclk, req_ready, tack));
    if (okk || wf)
      chk(swdio_oe === 1'b1 && swdio_out === 1'b0,
          $sformatf("R7 idle drive: oe=%b out=%b expected oe=1 out=0", swdio_oe, swdio_out));
    else
      chk(swdio_oe === 1'b0,
          $sformatf("R8 line released: oe=%b expected 0", swdio_oe));
    if (okk && rd)
      chk(rdata === data && par_err === flip_par,
          $sformatf("R10 read result: rdata=%h perr=%b expected rdata=%h perr=%b",
                    rdata, par_err, data, flip_par));
    @(negedge clk);
    chk(done === 1'b0 && ack === tack && (!(okk && rd) || rdata === data),
        $sformatf("R11 pulse/hold: done=%b ack=%b expected done=0 ack=%b", done, ack, tack));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && swclk === 1'b0 && swdio_oe === 1'b1 && swdio_out === 1'b0 &&
        done === 1'b0 && ack === 3'b000 && par_err === 1'b0,
        $sformatf("R1 reset: rdy=%b clk=%b oe=%b out=%b done=%b ack=%b expected 1 0 1 0 0 000",
                  req_ready, swclk, swdio_oe, swdio_out, done, ack));
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(req_ready === 1'b1 && swclk === 1'b0 && done === 1'b0,
        $sformatf("R1 idle without request: rdy=%b clk=%b done=%b expected 1 0 0", req_ready, swclk, done));
    access(1'b0, 1'b0, 2'b00, 32'h1234_5678, 2'd0, 3'b001, 1'b0, 1'b0);
    access(1'b1, 1'b1, 2'b11, 32'hA5A5_F00F, 2'd1, 3'b001, 1'b0, 1'b0);
    access(1'b0, 1'b1, 2'b01, 32'h0000_0001, 2'd3, 3'b001, 1'b1, 1'b0);
    access(1'b1, 1'b0, 2'b10, 32'hFFFF_FFFF, 2'd2, 3'b001, 1'b0, 1'b1);
    access(1'b1, 1'b0, 2'b01, 32'h8000_0000, 2'd0, 3'b001, 1'b0, 1'b0);
    access(1'b0, 1'b0, 2'b11, 32'hDEAD_BEEF, 2'd2, 3'b010, 1'b0, 1'b0);
    access(1'b1, 1'b1, 2'b00, 32'h0, 2'd1, 3'b100, 1'b0, 1'b1);
    access(1'b0, 1'b1, 2'b10, 32'h0, 2'd0, 3'b111, 1'b0, 1'b0);
    repeat (3) begin
      chk(swdio_oe === 1'b0 && req_ready === 1'b1,
          $sformatf("R8 stays released while idle: oe=%b rdy=%b expected oe=0 rdy=1", swdio_oe, req_ready));
      @(negedge clk);
    end
    access(1'b1, 1'b1, 2'b01, 32'h0, 2'd3, 3'b000, 1'b0, 1'b0);
    access(1'b0, 1'b1, 2'b00, 32'h0BC1_1477, 2'd0, 3'b001, 1'b0, 1'b1);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule